// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital side of a multi-channel successive-approximation converter. Software programs two 8-bit control registers over a simple register bus. The block then runs the analog core through a start/busy/done handshake and tells the core which channel to sample and which resolution to use. It also supplies a divided conversion-clock tick. Each returned sample is written into that channel's own result register, and software reads the results back over the same bus.

Two control bits select the operating mode. The sequence bit chooses between one channel and a scan. In one-channel operation the 3-bit channel field names the input to sample. In a scan, channels run upward from 0, and the same field names the final channel. The continuous bit chooses between a single pass, after which the block clears its own start bit, and repeated passes that run until software writes the start bit to 0. A halt input returns both registers to their reset value, which powers the core down. An overflow flag per channel records that a result was replaced before it was read. An interrupt output reports these flags when it is enabled and the global mask input is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, and one cycle after `halt_i` is high, both control registers read 0x00 and `cnv_pwr_o` is 0.
- R2: Control register A is at address 0 and control register B at address 1. Register A holds channel in bits 7:5, fast clock in bit 4, scan mode in bit 3, power in bit 2, repeat in bit 1 and start in bit 0. Register B holds pre-charge off in bit 4, external reference in bit 3, 8-bit mode in bit 2, overflow interrupt enable in bit 1 and auxiliary interrupt enable in bit 0. Register B bits 7:5 always read 0.
- R3: `irq_ovf_o` is 1 exactly when register B bit 1 is 1, `irq_mask_i` is 1 and at least one channel overflow flag is set.
- R4: `cnv_start_o` is never asserted unless both the power bit and the start bit are 1.
- R5: With scan mode 0 and repeat 0, setting start converts only the channel in bits 7:5, once, and then the start bit reads 0.
- R6: With scan mode 1, one pass converts channels 0, 1 and so on up to the value in bits 7:5, in that order.
- R7: With repeat 1, passes follow one another without new writes. After software writes start to 0, no further conversion is launched.
- R8: Each accepted result overwrites its channel's register. Bits 9:2 read at address 16+ch and bits 1:0 read in bits 1:0 of address 24+ch, with the upper bits 0.
- R9: `cnv_res8_o` follows register B bit 2. While that bit is 1, the stored result keeps bits 9:2 of the sample and stores bits 1:0 as zero.
- R10: A channel's overflow flag is set when a result arrives while the previous result is still unread. The flags read at address 2, bit n for channel n. Reading address 16+ch clears that channel's flag and its unread state.
- R11: While powered, `cnv_tick_o` is a one-cycle pulse every SLOW_DIV cycles when the fast bit is 0, and every SLOW_DIV/2 cycles when it is 1. It stays 0 while powered down.
- R12: `cnv_start_o` is a single-cycle pulse, issued only while `cnv_busy_i` is 0. No second start is issued until `cnv_done_i` returns the outstanding result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Forces the reset configuration |
| irq_mask_i | input | 1 | Global converter interrupt mask |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clears on read) |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| cnv_start_o | output | 1 | Start pulse to the analog core |
| cnv_busy_i | input | 1 | Core busy with a conversion |
| cnv_done_i | input | 1 | Core result valid for one cycle |
| cnv_data_i | input | 10 | Core conversion result |
| cnv_chan_o | output | 3 | Channel to sample |
| cnv_res8_o | output | 1 | 8-bit resolution request |
| cnv_pwr_o | output | 1 | Core power enable |
| cnv_tick_o | output | 1 | Divided conversion clock enable |
| irq_ovf_o | output | 1 | Overflow interrupt |

## Verification
A sequencer that holds the wrong channel shows the error on `cnv_chan_o` at the next start pulse, so the per-cycle model sees it within one conversion. If the unread or overflow state is wrong, `irq_ovf_o` changes on the very cycle after the store or the read-clear, and the bench compares that output on every clock while the mask is high. A start bit that is not cleared, or a repeat pass that does not stop, shows up as extra start pulses within a few cycles. It also shows on the register A readback once the stub core has gone idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W   = 3;
    localparam int NUM_CH = 1 << CH_W;
    localparam int RES_W  = 10;
    localparam int REG_W  = 8;

    localparam int ADR_CTL_A  = 0;
    localparam int ADR_CTL_B  = 1;
    localparam int ADR_OVF    = 2;
    localparam int ADR_RES_HI = 16;
    localparam int ADR_RES_LO = 24;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            fast;
        logic            scan;
        logic            pwr;
        logic            rpt;
        logic            start;
    } ctl_a_t;

    typedef struct packed {
        logic [2:0] spare;
        logic       prech_off;
        logic       ext_ref;
        logic       res8;
        logic       ovf_ie;
        logic       aux_ie;
    } ctl_b_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } sq_state_e;

    function automatic logic [RES_W-1:0] align_res(input logic [RES_W-1:0] raw,
                                                   input logic             res8);
        return res8 ? {raw[RES_W-1:2], 2'b00} : raw;
    endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              clr_start_i,
    output ctl_a_t            ctl_a_o,
    output ctl_b_t            ctl_b_o
);

    always_ff @(posedge clk) begin
        if (rst || halt_i) begin
            ctl_a_o <= '0;
            ctl_b_o <= '0;
        end else begin
            if (clr_start_i)
                ctl_a_o.start <= 1'b0;
            if (wr_i && addr_i == ADDR_W'(ADR_CTL_A))
                ctl_a_o <= ctl_a_t'(wdata_i);
            if (wr_i && addr_i == ADDR_W'(ADR_CTL_B))
                ctl_b_o <= ctl_b_t'({3'b000, wdata_i[4:0]});
        end
    end

endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fast_i,
    output logic tick_o
);

    localparam int FAST_DIV = SLOW_DIV / 2;
    localparam int CNT_W    = $clog2(SLOW_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim    = fast_i ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
    assign tick_o = en_i && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !en_i)
            cnt_q <= '0;
        else if (cnt_q >= lim)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            halt_i,
    input  ctl_a_t          ctl_a_i,
    input  logic            busy_i,
    input  logic            done_i,
    output logic            start_o,
    output logic [CH_W-1:0] chan_o,
    output logic            store_o,
    output logic            clr_start_o
);

    sq_state_e       st_q;
    logic [CH_W-1:0] ch_q;
    logic [CH_W-1:0] first_ch;
    logic            run_ok;
    logic            pass_end;

    assign run_ok      = ctl_a_i.pwr && ctl_a_i.start;
    assign first_ch    = ctl_a_i.scan ? '0 : ctl_a_i.chan;
    assign pass_end    = !ctl_a_i.scan || (ch_q >= ctl_a_i.chan);
    assign start_o     = run_ok && (st_q == SQ_LAUNCH) && !busy_i;
    assign store_o     = run_ok && (st_q == SQ_WAIT) && done_i;
    assign clr_start_o = store_o && pass_end && !ctl_a_i.rpt;
    assign chan_o      = ch_q;

    always_ff @(posedge clk) begin
        if (rst || halt_i) begin
            st_q <= SQ_IDLE;
            ch_q <= '0;
        end else if (!run_ok) begin
            st_q <= SQ_IDLE;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    ch_q <= first_ch;
                    st_q <= SQ_LAUNCH;
                end
                SQ_LAUNCH: begin
                    if (!busy_i)
                        st_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (done_i) begin
                        if (!pass_end) begin
                            ch_q <= ch_q + 1'b1;
                            st_q <= SQ_LAUNCH;
                        end else if (ctl_a_i.rpt) begin
                            ch_q <= first_ch;
                            st_q <= SQ_LAUNCH;
                        end else begin
                            st_q <= SQ_IDLE;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          store_i,
    input  logic [CH_W-1:0]               ch_i,
    input  logic [RES_W-1:0]              data_i,
    input  logic                          res8_i,
    input  logic [NUM_CH-1:0]             clr_i,
    output logic [NUM_CH-1:0][RES_W-1:0]  res_o,
    output logic [NUM_CH-1:0]             ovf_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [RES_W-1:0] val_q;
        logic             unread_q;
        logic             ovf_q;
        logic             hit;

        assign hit      = store_i && (ch_i == CH_W'(i));
        assign res_o[i] = val_q;
        assign ovf_o[i] = ovf_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q    <= '0;
                unread_q <= 1'b0;
                ovf_q    <= 1'b0;
            end else if (hit) begin
                val_q    <= align_res(data_i, res8_i);
                unread_q <= 1'b1;
                ovf_q    <= !clr_i[i] && (ovf_q || unread_q);
            end else if (clr_i[i]) begin
                unread_q <= 1'b0;
                ovf_q    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int SLOW_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_i,
    input  logic              irq_mask_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              cnv_start_o,
    input  logic              cnv_busy_i,
    input  logic              cnv_done_i,
    input  logic [9:0]        cnv_data_i,
    output logic [2:0]        cnv_chan_o,
    output logic              cnv_res8_o,
    output logic              cnv_pwr_o,
    output logic              cnv_tick_o,
    output logic              irq_ovf_o
);

    localparam int TAG_W = ADDR_W - CH_W;
    localparam logic [TAG_W-1:0] HI_TAG = TAG_W'(ADR_RES_HI >> CH_W);
    localparam logic [TAG_W-1:0] LO_TAG = TAG_W'(ADR_RES_LO >> CH_W);

    ctl_a_t                       c1_q;
    ctl_b_t                       c2_q;
    logic                         store;
    logic                         clr_start;
    logic [NUM_CH-1:0][RES_W-1:0] res;
    logic [NUM_CH-1:0]            ovf;
    logic [NUM_CH-1:0]            rd_clr;
    logic [CH_W-1:0]              idx;
    logic                         hi_sel;
    logic                         lo_sel;

    assign idx    = bus_addr_i[CH_W-1:0];
    assign hi_sel = bus_addr_i[ADDR_W-1:CH_W] == HI_TAG;
    assign lo_sel = bus_addr_i[ADDR_W-1:CH_W] == LO_TAG;
    assign rd_clr = (bus_rd_i && hi_sel) ? (NUM_CH'(1) << idx) : '0;

    adc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .halt_i     (halt_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .clr_start_i(clr_start),
        .ctl_a_o    (c1_q),
        .ctl_b_o    (c2_q)
    );

    adc_clk_div #(.SLOW_DIV(SLOW_DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .en_i  (c1_q.pwr),
        .fast_i(c1_q.fast),
        .tick_o(cnv_tick_o)
    );

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .halt_i     (halt_i),
        .ctl_a_i    (c1_q),
        .busy_i     (cnv_busy_i),
        .done_i     (cnv_done_i),
        .start_o    (cnv_start_o),
        .chan_o     (cnv_chan_o),
        .store_o    (store),
        .clr_start_o(clr_start)
    );

    adc_result_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .store_i(store),
        .ch_i   (cnv_chan_o),
        .data_i (cnv_data_i),
        .res8_i (c2_q.res8),
        .clr_i  (rd_clr),
        .res_o  (res),
        .ovf_o  (ovf)
    );

    assign cnv_pwr_o  = c1_q.pwr;
    assign cnv_res8_o = c2_q.res8;
    assign irq_ovf_o  = c2_q.ovf_ie && irq_mask_i && (|ovf);

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(ADR_CTL_A))
            bus_rdata_o = c1_q;
        else if (bus_addr_i == ADDR_W'(ADR_CTL_B))
            bus_rdata_o = c2_q;
        else if (bus_addr_i == ADDR_W'(ADR_OVF))
            bus_rdata_o = REG_W'(ovf);
        else if (hi_sel)
            bus_rdata_o = res[idx][RES_W-1:2];
        else if (lo_sel)
            bus_rdata_o = REG_W'(res[idx][1:0]);
    end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       halt_i,
    input logic       irq_mask_i,
    input logic       cnv_start_o,
    input logic       cnv_pwr_o,
    input logic       cnv_tick_o,
    input logic       irq_ovf_o,
    input logic [7:0] c1_q,
    input logic [7:0] c2_q
);

    assert_halt_clears_R1: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> (c1_q == 8'h00 && c2_q == 8'h00));

    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
        irq_ovf_o |-> irq_mask_i);

    assert_start_powered_R4: assert property (@(posedge clk) disable iff (rst)
        cnv_start_o |-> cnv_pwr_o);

    assert_tick_single_R11: assert property (@(posedge clk) disable iff (rst)
        cnv_tick_o |=> !cnv_tick_o);

    assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        cnv_start_o |=> !cnv_start_o);

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .halt_i     (halt_i),
    .irq_mask_i (irq_mask_i),
    .cnv_start_o(cnv_start_o),
    .cnv_pwr_o  (cnv_pwr_o),
    .cnv_tick_o (cnv_tick_o),
    .irq_ovf_o  (irq_ovf_o),
    .c1_q       (c1_q),
    .c2_q       (c2_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int SLOW_DIV   = 8;
    localparam int LAT        = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              halt_i = 1'b0;
    logic              irq_mask_i = 1'b0;
    logic              bus_wr_i = 1'b0;
    logic              bus_rd_i = 1'b0;
    logic [ADDR_W-1:0] bus_addr_i = '0;
    logic [7:0]        bus_wdata_i = '0;
    logic [7:0]        bus_rdata_o;
    logic              cnv_start_o;
    logic              cnv_busy_i;
    logic              cnv_done_i;
    logic [9:0]        cnv_data_i;
    logic [2:0]        cnv_chan_o;
    logic              cnv_res8_o;
    logic              cnv_pwr_o;
    logic              cnv_tick_o;
    logic              irq_ovf_o;

    adc_seq_ctrl #(.ADDR_W(ADDR_W), .SLOW_DIV(SLOW_DIV)) i_adc_seq_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural converter core stub
    bit       pend = 0;
    bit       busy_s = 0;
    logic     done_s = 1'b0;
    logic [9:0] data_s = '0;
    int       lat = 0;
    int       st_ch = 0;
    int       conv_total = 0;
    int       n_starts = 0;

    assign cnv_busy_i = busy_s;
    assign cnv_done_i = done_s;
    assign cnv_data_i = data_s;

    always @(negedge clk) begin
        if (rst) begin
            pend = 0; busy_s = 0; done_s = 1'b0; lat = 0;
        end else begin
            done_s = 1'b0;
            if (busy_s) begin
                if (lat <= 1) begin
                    done_s = 1'b1;
                    busy_s = 0;
                    data_s = 10'(st_ch * 97 + conv_total * 13 + 5);
                    conv_total++;
                end else begin
                    lat--;
                end
            end
            if (pend) begin
                busy_s = 1; lat = LAT; pend = 0;
            end
            if (cnv_start_o) begin
                pend = 1; st_ch = int'(cnv_chan_o); n_starts++;
            end
        end
    end

    // Reference model, updated on every rising edge
    logic [7:0] m_c1 = '0;
    logic [7:0] m_c2 = '0;
    logic [9:0] m_res [8];
    logic [7:0] m_unread = '0;
    logic [7:0] m_ovf = '0;
    bit         m_inpass = 0;
    int         m_next = 0;

    always @(posedge clk) begin
        int c;
        logic [9:0] v;
        bit last;
        if (rst) begin
            m_c1 = '0; m_c2 = '0; m_unread = '0; m_ovf = '0; m_inpass = 0;
            for (int i = 0; i < 8; i++) m_res[i] = '0;
        end else begin
            if (cnv_done_i && m_c1[2] && m_c1[0]) begin
                c = st_ch;
                v = m_c2[2] ? {cnv_data_i[9:2], 2'b00} : cnv_data_i;
                m_res[c] = v;
                if (m_unread[c]) m_ovf[c] = 1'b1;
                m_unread[c] = 1'b1;
                last = !m_c1[3] || (c >= int'(m_c1[7:5]));
                if (!last) begin
                    m_inpass = 1; m_next = c + 1;
                end else begin
                    m_inpass = 0;
                    if (!m_c1[1]) m_c1[0] = 1'b0;
                end
            end
            if (bus_rd_i && bus_addr_i[4:3] == 2'b10) begin
                m_unread[bus_addr_i[2:0]] = 1'b0;
                m_ovf[bus_addr_i[2:0]] = 1'b0;
            end
            if (halt_i) begin
                m_c1 = '0; m_c2 = '0;
            end else if (bus_wr_i) begin
                if (bus_addr_i == 5'd0) m_c1 = bus_wdata_i;
                if (bus_addr_i == 5'd1) m_c2 = {3'b000, bus_wdata_i[4:0]};
            end
            if (!(m_c1[2] && m_c1[0])) m_inpass = 0;
        end
    end

    // Per-clock comparison against the model
    always begin
        int ec;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!rst) begin
            chk(irq_ovf_o == (m_c2[1] && irq_mask_i && (|m_ovf)), "R3", "irq_ovf_o",
                int'(irq_ovf_o), int'(m_c2[1] && irq_mask_i && (|m_ovf)));
            chk(cnv_pwr_o == m_c1[2], "R1", "cnv_pwr_o", int'(cnv_pwr_o), int'(m_c1[2]));
            chk(cnv_res8_o == m_c2[2], "R9", "cnv_res8_o", int'(cnv_res8_o), int'(m_c2[2]));
            chk(!cnv_tick_o || cnv_pwr_o, "R11", "tick while unpowered", int'(cnv_tick_o), 0);
            chk(!(cnv_start_o && (pend || busy_s)), "R12", "start while outstanding",
                int'(cnv_start_o), 0);
            if (cnv_start_o) begin
                ec = m_inpass ? m_next : (m_c1[3] ? 0 : int'(m_c1[7:5]));
                chk(m_c1[2] && m_c1[0], "R4", "start without power/start", int'(m_c1), 8'h05);
                chk(int'(cnv_chan_o) == ec, "R6", "channel order", int'(cnv_chan_o), ec);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual %0d expected < 100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = ADDR_W'(a); bus_wdata_i = 8'(d);
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = ADDR_W'(a);
        #(CLK_PERIOD/4);
        chk(bus_rdata_o == 8'(exp), req, $sformatf("read addr %0d", a),
            int'(bus_rdata_o), exp & 8'hFF);
        @(negedge clk);
        bus_rd_i = 1'b0;
    endtask

    task automatic settle();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while ((m_c1[0] || busy_s || pend) && k < 3000);
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input int exp);
        int t0;
        repeat (4) @(posedge clk);
        do begin @(posedge clk); #(CLK_PERIOD/4); end while (!cnv_tick_o);
        t0 = cyc;
        do begin @(posedge clk); #(CLK_PERIOD/4); end while (!cnv_tick_o);
        chk(cyc - t0 == exp, "R11", "tick period", cyc - t0, exp);
    endtask

    initial begin
        int s;
        int s2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, 8'h00, "R1");
        rd(1, 8'h00, "R1");
        rd(2, 8'h00, "R1");

        // R2 register layout and masking
        wr(1, 8'hFF);
        rd(1, 8'h1F, "R2");
        wr(1, 8'h02);
        rd(1, 8'h02, "R2");

        // R4 start without power
        s = n_starts;
        wr(0, 8'h61);
        repeat (30) @(negedge clk);
        chk(n_starts == s, "R4", "starts while unpowered", n_starts - s, 0);
        rd(0, 8'h61, "R2");
        wr(0, 8'h00);

        // R5 single channel, single pass
        s = n_starts;
        wr(0, 8'hA5);
        settle();
        chk(n_starts - s == 1, "R5", "conversion count", n_starts - s, 1);
        rd(0, 8'hA4, "R5");
        rd(16 + 5, int'(m_res[5][9:2]), "R8");
        rd(24 + 5, int'(m_res[5][1:0]), "R8");

        // R6 scan 0..3, single pass
        s = n_starts;
        wr(0, 8'h6D);
        settle();
        chk(n_starts - s == 4, "R6", "scan conversion count", n_starts - s, 4);
        rd(0, 8'h6C, "R6");
        for (int c = 0; c < 4; c++) begin
            rd(16 + c, int'(m_res[c][9:2]), "R8");
            rd(24 + c, int'(m_res[c][1:0]), "R8");
        end

        // R10 / R3 overflow on channel 2
        irq_mask_i = 1'b1;
        wr(0, 8'h45);
        settle();
        wr(0, 8'h45);
        settle();
        chk(irq_ovf_o == 1'b1, "R3", "irq with mask and enable", int'(irq_ovf_o), 1);
        rd(2, 8'h04, "R10");
        @(negedge clk);
        irq_mask_i = 1'b0;
        #(CLK_PERIOD/4);
        chk(irq_ovf_o == 1'b0, "R3", "irq with mask low", int'(irq_ovf_o), 0);
        rd(16 + 2, int'(m_res[2][9:2]), "R10");
        rd(2, 8'h00, "R10");

        // R9 8-bit mode on channel 1
        wr(1, 8'h06);
        wr(0, 8'h25);
        settle();
        chk(cnv_res8_o == 1'b1, "R9", "cnv_res8_o", int'(cnv_res8_o), 1);
        rd(24 + 1, 8'h00, "R9");
        rd(16 + 1, int'(m_res[1][9:2]), "R9");

        // R7 repeating scan 0..2, then stop
        wr(1, 8'h02);
        s = n_starts;
        wr(0, 8'h4F);
        for (int k = 0; k < 2000 && (n_starts - s) < 9; k++) @(negedge clk);
        wr(0, 8'h4E);
        settle();
        s2 = n_starts;
        chk(s2 - s >= 9, "R7", "repeated conversions", s2 - s, 9);
        repeat (60) @(negedge clk);
        chk(n_starts == s2, "R7", "starts after stop", n_starts - s2, 0);
        rd(0, 8'h4E, "R7");

        // R11 tick period in both speeds
        wr(0, 8'h04);
        measure(SLOW_DIV);
        wr(0, 8'h14);
        measure(SLOW_DIV / 2);

        // R1 halt restores reset configuration
        wr(1, 8'h1F);
        wr(0, 8'h25);
        @(negedge clk);
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        rd(0, 8'h00, "R1");
        rd(1, 8'h00, "R1");
        chk(cnv_pwr_o == 1'b0, "R1", "power after halt", int'(cnv_pwr_o), 0);
        repeat (20) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule